// File: doc/BRIEF.md
# Prescaled Timer with Match Channels and Edge Capture

This block is a free-running timer for a control subsystem. A prescale counter divides the clock, and the timer count advances by one each time the prescale counter reaches its limit. Four match channels each hold a compare value. Each channel can raise an interrupt flag, send the count back to zero, or halt the timer when the count equals its value at an advance point. One capture input is synchronised, checked for edges, and on a selected edge copies the timer count into a capture register.

Software controls everything through a word-addressed read/write port. Status flags are cleared by writing ones. A single interrupt line is high while any flag is set. The usual pattern is to program the prescale limit, the match values and the control words, set the run bit, and then service interrupts by reading status and clearing the flags that were handled.

Top module: `mc_timer`

## Requirements
- R1: After reset every register reads 0, the timer is not running, rd_data is 0 and irq is 0.
- R2: While the run bit (CTRL bit 0, address 0) is 1 and the prescale limit (address 4) is P, the prescale counter (address 3) steps 0..P and wraps to 0, and the count (address 2) increments once per wrap. When the run bit is 0, both counters hold. Writing CTRL with bit 1 set clears both counters.
- R3: A channel matches when it is at an advance point and the count equals its match value (channel c at address 8+c, reset value 0). With its interrupt enable set, status bit c is set.
- R4: A match on a channel with reset enabled loads 0 into the count instead of the incremented value.
- R5: A match on a channel with stop enabled keeps the count at the match value, halts the prescale counter at 0 and clears the run bit, which then reads back 0.
- R6: With reset and stop both enabled on the matching channel, the count becomes 0 and the timer stops in the same cycle.
- R7: The match control word (address 5) holds three bits per channel c: interrupt at bit 3c, reset at 3c+1, stop at 3c+2. Bits 31:12 are ignored on write and read back as 0.
- R8: Channels that match in the same cycle set their status bits independently.
- R9: The capture control word (address 6) enables capture on rising edges (bit 0), falling edges (bit 1) or both. A selected edge on cap_in, seen through a two-flop synchroniser, loads the count into the capture register (address 7). An edge that is not selected changes nothing.
- R10: Capture control bit 2 sets status bit 4 on each capture. Without it the capture register still loads and no flag is set.
- R11: Writing 1 to a status bit (address 1) clears it. Writing 0 leaves it unchanged. A flag set in the same cycle as its clear stays set.
- R12: irq is 1 exactly when any status bit is set, and it changes in the same cycle as the status register.
- R13: A read with rd_en returns the addressed register on rd_data one cycle later. In cycles after no read, rd_data is 0. Writes to CTRL, count, prescale counter, prescale limit and match values take effect at the next clock edge and override the timer's own update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| cap_in | input | 1 | Asynchronous capture input |
| irq | output | 1 | High while any status flag is set |

## Verification
The assertions rely on three conditions. Reset is held long enough to clear the synchroniser. No register write lands in the cycle a stop or reset match is checked, because a write deliberately wins over the timer's own update. cap_in is low when reset is released. The stimulus programs the timer only while it is halted, or at edges worked out ahead of time, and all register writes happen in negative-edge tasks. cap_in is held low through reset and changes only at negative edges, and each capture check waits several cycles so that the synchroniser latency is covered.

// File: rtl/mct_pkg.sv
package mct_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'd2;
  localparam logic [ADDR_W-1:0] A_PCNT = 4'd3;
  localparam logic [ADDR_W-1:0] A_PLIM = 4'd4;
  localparam logic [ADDR_W-1:0] A_MCTL = 4'd5;
  localparam logic [ADDR_W-1:0] A_CCTL = 4'd6;
  localparam logic [ADDR_W-1:0] A_CAPT = 4'd7;
  localparam logic [ADDR_W-1:0] A_MR0  = 4'd8;
  localparam int ACT_BITS = 3;
  localparam int CAP_CTL_W = 3;
  typedef struct packed {
    logic stop_en;
    logic rst_en;
    logic irq_en;
  } match_act_t;
endpackage

// File: rtl/mct_count_core.sv
module mct_count_core #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [DW-1:0] plim,
  input  logic          clr,
  input  logic          tc_wr,
  input  logic          pc_wr,
  input  logic [DW-1:0] wdata,
  input  logic          hit_rst,
  input  logic          hit_stop,
  output logic          tick,
  output logic [DW-1:0] tc_q,
  output logic [DW-1:0] pc_q
);
  logic [DW-1:0] tc_d, pc_d;

  always_comb begin
    tick = run && (pc_q == plim);
  end

  always_comb begin
    pc_d = pc_q;
    if (clr)            pc_d = '0;
    else if (pc_wr)     pc_d = wdata;
    else if (tick)      pc_d = '0;
    else if (run)       pc_d = pc_q + 1'b1;
  end

  always_comb begin
    tc_d = tc_q;
    if (clr)            tc_d = '0;
    else if (tc_wr)     tc_d = wdata;
    else if (tick) begin
      if (hit_rst)       tc_d = '0;
      else if (hit_stop) tc_d = tc_q;
      else               tc_d = tc_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_q <= '0;
      pc_q <= '0;
    end else begin
      tc_q <= tc_d;
      pc_q <= pc_d;
    end
  end
endmodule

// File: rtl/mct_match_chan.sv
module mct_match_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          tick,
  input  logic [DW-1:0] tc,
  output logic [DW-1:0] match_val,
  output logic          hit
);
  always_ff @(posedge clk) begin
    if (rst)     match_val <= '0;
    else if (wr) match_val <= wdata;
  end

  always_comb begin
    hit = tick && (tc == match_val);
  end
endmodule

// File: rtl/mct_capture.sv
module mct_capture #(
  parameter int DW = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_in,
  input  logic          rise_en,
  input  logic          fall_en,
  input  logic [DW-1:0] tc,
  output logic [DW-1:0] cap_val,
  output logic          cap_evt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur, rise, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], cap_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  always_comb begin
    cur     = sync_q[SYNC_STAGES-1];
    rise    = cur & ~prev_q;
    fall    = ~cur & prev_q;
    cap_evt = (rise & rise_en) | (fall & fall_en);
  end

  always_ff @(posedge clk) begin
    if (rst)          cap_val <= '0;
    else if (cap_evt) cap_val <= tc;
  end
endmodule

// File: rtl/mc_timer.sv
module mc_timer
  import mct_pkg::*;
#(
  parameter int DW  = 32,
  parameter int NCH = 4,
  parameter int AW  = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          cap_in,
  output logic          irq
);
  localparam int MCW = ACT_BITS * NCH;
  localparam int FLW = NCH + 1;

  logic                 run_q;
  logic [MCW-1:0]       mcr_q;
  logic [CAP_CTL_W-1:0] ccr_q;
  logic [DW-1:0]        plim_q;
  logic [FLW-1:0]       flags_q, flags_d, flag_set, flag_clr;
  logic [DW-1:0]        tc_q, pc_q, cap_val, rd_mux;
  logic [DW-1:0]        mr_val [NCH];
  logic [NCH-1:0]       hit, irq_vec, rst_vec, stop_vec, wr_mr;
  logic                 tick, cap_evt, hit_rst, hit_stop;
  logic                 wr_ctrl, wr_stat, wr_cnt, wr_pcnt, wr_plim, wr_mctl, wr_cctl;

  always_comb begin
    wr_ctrl = wr_en && (addr == A_CTRL);
    wr_stat = wr_en && (addr == A_STAT);
    wr_cnt  = wr_en && (addr == A_CNT);
    wr_pcnt = wr_en && (addr == A_PCNT);
    wr_plim = wr_en && (addr == A_PLIM);
    wr_mctl = wr_en && (addr == A_MCTL);
    wr_cctl = wr_en && (addr == A_CCTL);
  end

  mct_count_core #(.DW(DW)) u_core (
    .clk(clk), .rst(rst), .run(run_q), .plim(plim_q),
    .clr(wr_ctrl && wr_data[1]), .tc_wr(wr_cnt), .pc_wr(wr_pcnt),
    .wdata(wr_data), .hit_rst(hit_rst), .hit_stop(hit_stop),
    .tick(tick), .tc_q(tc_q), .pc_q(pc_q)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    match_act_t act;
    assign act          = match_act_t'(mcr_q[ACT_BITS*ch +: ACT_BITS]);
    assign irq_vec[ch]  = act.irq_en;
    assign rst_vec[ch]  = act.rst_en;
    assign stop_vec[ch] = act.stop_en;
    assign wr_mr[ch]    = wr_en && (addr == AW'(int'(A_MR0) + ch));

    mct_match_chan #(.DW(DW)) u_chan (
      .clk(clk), .rst(rst), .wr(wr_mr[ch]), .wdata(wr_data),
      .tick(tick), .tc(tc_q), .match_val(mr_val[ch]), .hit(hit[ch])
    );
  end

  assign hit_rst  = |(hit & rst_vec);
  assign hit_stop = |(hit & stop_vec);

  mct_capture #(.DW(DW), .SYNC_STAGES(2)) u_cap (
    .clk(clk), .rst(rst), .cap_in(cap_in),
    .rise_en(ccr_q[0]), .fall_en(ccr_q[1]), .tc(tc_q),
    .cap_val(cap_val), .cap_evt(cap_evt)
  );

  always_comb begin
    flag_set = {cap_evt & ccr_q[2], hit & irq_vec};
    flag_clr = wr_stat ? wr_data[FLW-1:0] : '0;
    flags_d  = (flags_q & ~flag_clr) | flag_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      mcr_q   <= '0;
      ccr_q   <= '0;
      plim_q  <= '0;
      flags_q <= '0;
      irq     <= 1'b0;
    end else begin
      if (wr_ctrl)       run_q <= wr_data[0];
      else if (hit_stop) run_q <= 1'b0;
      if (wr_mctl) mcr_q  <= wr_data[MCW-1:0];
      if (wr_cctl) ccr_q  <= wr_data[CAP_CTL_W-1:0];
      if (wr_plim) plim_q <= wr_data;
      flags_q <= flags_d;
      irq     <= |flags_d;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL:  rd_mux = DW'(run_q);
      A_STAT:  rd_mux = DW'(flags_q);
      A_CNT:   rd_mux = tc_q;
      A_PCNT:  rd_mux = pc_q;
      A_PLIM:  rd_mux = plim_q;
      A_MCTL:  rd_mux = DW'(mcr_q);
      A_CCTL:  rd_mux = DW'(ccr_q);
      A_CAPT:  rd_mux = cap_val;
      default: begin
        for (int c = 0; c < NCH; c++) begin
          if (addr == AW'(int'(A_MR0) + c)) rd_mux = mr_val[c];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_en ? rd_mux : '0;
  end
endmodule

// File: rtl/mc_timer_chk.sv
module mc_timer_chk
  import mct_pkg::*;
#(
  parameter int DW  = 32,
  parameter int NCH = 4,
  parameter int AW  = ADDR_W
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic [AW-1:0]         addr,
  input logic                  run_q,
  input logic [DW-1:0]         tc_q,
  input logic [DW-1:0]         pc_q,
  input logic [NCH-1:0]        hit,
  input logic [ACT_BITS*NCH-1:0] mcr_q,
  input logic [NCH:0]          flags_q,
  input logic                  cap_evt,
  input logic                  irq
);
  logic [NCH-1:0] want_rst, want_stop;
  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      want_rst[c]  = mcr_q[ACT_BITS*c + 1];
      want_stop[c] = mcr_q[ACT_BITS*c + 2];
    end
  end

  assert_irq_follows_flags_R12: assert property (@(posedge clk) disable iff (rst)
    irq == (|flags_q));

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !wr_en) |=> ($stable(tc_q) && $stable(pc_q)));

  assert_stop_clears_run_R5: assert property (@(posedge clk) disable iff (rst)
    ((|(hit & want_stop)) && !(wr_en && addr == A_CTRL)) |=> !run_q);

  assert_match_zeroes_count_R4: assert property (@(posedge clk) disable iff (rst)
    ((|(hit & want_rst)) && !wr_en) |=> (tc_q == '0));

  assert_cap_flag_source_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_q[NCH]) |-> $past(cap_evt));

  assert_no_hit_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> (hit == '0));
endmodule

bind mc_timer mc_timer_chk #(.DW(DW), .NCH(NCH), .AW(AW)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .run_q(run_q),
  .tc_q(tc_q), .pc_q(pc_q), .hit(hit), .mcr_q(mcr_q), .flags_q(flags_q),
  .cap_evt(cap_evt), .irq(irq)
);

// File: tb/mc_timer_tb_top.sv
module mc_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, cap_in = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_timer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .cap_in(cap_in), .irq(irq)
  );

  // Behavioural reference model
  bit          m_run;
  int unsigned m_tc, m_pc, m_plim, m_cap, m_rd;
  int unsigned m_mr [4];
  bit [11:0]   m_mctl;
  bit [2:0]    m_cctl;
  bit [4:0]    m_flags;
  bit          m_irq;
  bit          hist [$];

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_tc = 0; m_pc = 0; m_plim = 0; m_cap = 0; m_rd = 0;
      foreach (m_mr[i]) m_mr[i] = 0;
      m_mctl = 0; m_cctl = 0; m_flags = 0; m_irq = 0;
      hist = '{0, 0, 0};
    end else begin
      bit adv, any_rst, any_stop, edge_up, edge_dn, cap_hit;
      bit [4:0] setv, clrv;
      int unsigned n_tc, n_pc;
      bit n_run;
      case (addr)
        0: m_rd = m_run;
        1: m_rd = m_flags;
        2: m_rd = m_tc;
        3: m_rd = m_pc;
        4: m_rd = m_plim;
        5: m_rd = m_mctl;
        6: m_rd = m_cctl;
        7: m_rd = m_cap;
        default: m_rd = (addr < 12) ? m_mr[addr-8] : 0;
      endcase
      if (!rd_en) m_rd = 0;
      adv = m_run && (m_pc == m_plim);
      any_rst = 0; any_stop = 0; setv = 0;
      for (int c = 0; c < 4; c++) begin
        if (adv && m_tc == m_mr[c]) begin
          if (m_mctl[3*c])   setv[c] = 1;
          if (m_mctl[3*c+1]) any_rst = 1;
          if (m_mctl[3*c+2]) any_stop = 1;
        end
      end
      n_tc = m_tc; n_pc = m_pc; n_run = m_run;
      if (adv) begin
        n_pc = 0;
        if (any_rst) n_tc = 0;
        else if (!any_stop) n_tc = m_tc + 1;
      end else if (m_run) n_pc = m_pc + 1;
      if (any_stop) n_run = 0;
      edge_up = hist[1] && !hist[2];
      edge_dn = !hist[1] && hist[2];
      cap_hit = (edge_up && m_cctl[0]) || (edge_dn && m_cctl[1]);
      if (cap_hit) begin
        m_cap = m_tc;
        if (m_cctl[2]) setv[4] = 1;
      end
      clrv = 0;
      if (wr_en) begin
        case (addr)
          0: begin n_run = wr_data[0]; if (wr_data[1]) begin n_tc = 0; n_pc = 0; end end
          1: clrv = wr_data[4:0];
          2: n_tc = wr_data;
          3: n_pc = wr_data;
          4: m_plim = wr_data;
          5: m_mctl = wr_data[11:0];
          6: m_cctl = wr_data[2:0];
          default: if (addr >= 8 && addr < 12) m_mr[addr-8] = wr_data;
        endcase
      end
      m_flags = (m_flags & ~clrv) | setv;
      m_irq = |m_flags;
      m_tc = n_tc; m_pc = n_pc; m_run = n_run;
      hist.push_front(cap_in);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({31'd0, irq}, {31'd0, m_irq}, "R12 irq vs model");
      chk(rd_data, m_rd, "R13 rd_data vs model");
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    chk(rd_data, exp, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(rd_data, 0, "R1 rd_data");
    chk({31'd0, irq}, 0, "R1 irq");
    rd_chk(0, 0, "R1 ctrl");
    rd_chk(2, 0, "R1 count");
    rd_chk(1, 0, "R1 status");
    rd_chk(8, 0, "R1 match0");
    @(negedge clk);
    chk(rd_data, 0, "R13 idle rd_data");

    // R2 prescaled counting
    wr(4, 2); wr(2, 0); wr(0, 1);
    repeat (8) @(negedge clk);
    wr(0, 0);
    rd_chk(2, 3, "R2 count after 9 cycles");
    rd_chk(3, 0, "R2 prescale wrapped");

    // R3 / R4 interrupt and reset on match
    wr(4, 0); wr(8, 5); wr(5, 32'h3); wr(2, 0); wr(0, 1);
    repeat (8) @(negedge clk);
    wr(0, 0);
    rd_chk(2, 3, "R4 count restarted");
    rd_chk(1, 1, "R3 flag0 set");
    chk({31'd0, irq}, 1, "R12 irq high");
    wr(1, 1);
    rd_chk(1, 0, "R11 flag cleared");
    chk({31'd0, irq}, 0, "R12 irq low");

    // R5 stop on match
    wr(4, 1); wr(9, 4); wr(5, 32'h28); wr(2, 0); wr(0, 1);
    repeat (20) @(negedge clk);
    rd_chk(0, 0, "R5 run bit cleared");
    rd_chk(2, 4, "R5 count held");
    rd_chk(3, 0, "R5 prescale halted");
    rd_chk(1, 2, "R5 flag1 set");
    wr(1, 32'h1F);

    // R6 reset and stop together
    wr(4, 0); wr(10, 7); wr(5, 32'h180); wr(2, 0); wr(0, 1);
    repeat (15) @(negedge clk);
    rd_chk(2, 0, "R6 count zero");
    rd_chk(0, 0, "R6 stopped");
    rd_chk(1, 0, "R6 no flag");

    // R7 control layout
    wr(5, 32'hFFFF_FFFF);
    rd_chk(5, 32'hFFF, "R7 reserved bits");
    wr(5, 0);

    // R8 simultaneous matches
    wr(8, 3); wr(9, 3); wr(11, 3); wr(5, 32'h209); wr(2, 0); wr(0, 1);
    repeat (10) @(negedge clk);
    wr(0, 0);
    rd_chk(1, 32'hB, "R8 independent flags");
    wr(1, 32'h1F);
    rd_chk(1, 0, "R11 all cleared");

    // R11 set wins over clear
    wr(8, 2); wr(5, 32'h1); wr(2, 0); wr(0, 1);
    repeat (2) @(negedge clk);
    wr(1, 1);
    wr(0, 0);
    rd_chk(1, 1, "R11 set beats clear");
    wr(1, 32'h1F);
    wr(5, 0);

    // R9 / R10 capture
    wr(2, 77); wr(6, 1);
    cap_in = 1;
    repeat (5) @(negedge clk);
    rd_chk(7, 77, "R9 rising capture");
    rd_chk(1, 0, "R10 no flag without enable");
    wr(6, 2); wr(2, 55);
    cap_in = 0;
    repeat (5) @(negedge clk);
    rd_chk(7, 55, "R9 falling capture");
    wr(2, 66);
    cap_in = 1;
    repeat (5) @(negedge clk);
    rd_chk(7, 55, "R9 rising ignored");
    wr(6, 3); wr(2, 33);
    cap_in = 0;
    repeat (5) @(negedge clk);
    rd_chk(7, 33, "R9 both edges fall");
    wr(2, 44);
    cap_in = 1;
    repeat (5) @(negedge clk);
    rd_chk(7, 44, "R9 both edges rise");
    wr(6, 5);
    cap_in = 0;
    repeat (5) @(negedge clk);
    rd_chk(1, 0, "R10 fall not selected");
    wr(2, 88);
    cap_in = 1;
    repeat (5) @(negedge clk);
    rd_chk(7, 88, "R9 capture value");
    rd_chk(1, 32'h10, "R10 capture flag");
    chk({31'd0, irq}, 1, "R12 irq from capture");
    wr(1, 32'h10);

    // Running capture, checked against the model
    wr(6, 7); wr(0, 1);
    for (int k = 0; k < 6; k++) begin
      cap_in = ~cap_in;
      repeat (3 + k) @(negedge clk);
      rd_en = 1; addr = 7;
      @(negedge clk);
      rd_en = 0;
    end
    wr(0, 0);
    rd_en = 1; addr = 1;
    @(negedge clk);
    rd_en = 0;
    @(negedge clk);
    finish_run();
  end
endmodule